// File: doc/BRIEF.md
# Modulator Clock Generator and Bitstream Capture

This block drives the sampling clock of an external 1-bit delta-sigma modulator and takes back the bitstream that the modulator returns. The modulator clock is an integer division of the system clock. A requested ratio is accepted only if the clock it produces keeps its period, its high and low phases and its duty cycle inside fixed legal windows. If a ratio fails these limits, the block keeps the ratio already in use and raises an error flag.

The modulator changes its data line shortly after each falling edge of the clock it receives. The block captures that line at the next rising edge, which gives a full low phase of settling time. Each captured bit appears on a registered output together with a strobe that lasts one system cycle, and the downstream decimation filter reads the bit on that strobe.

A run-length detector watches the captured bits. A modulator driven past full scale returns an unbroken run of ones, or of zeros. When the run of identical bits reaches a programmable length, the detector raises a clip flag and reports which rail was hit.

Top module: `mdm_clk_capture`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `mclk_o`, `bit_vld_o`, `clip_o` and `ratio_err_o` are all low, and the active ratio is `RESET_RATIO` (6 by default).
- R2: With an active ratio N, the rising edges of `mclk_o` come exactly N system cycles apart. The high phase lasts ceil(N/2) cycles and the low phase lasts floor(N/2) cycles.
- R3: A ratio is legal only if its period is between 45.5 ns and 200 ns and each of its high and low phases is between 20 ns and 120 ns, measured with the system clock period `SYS_PS`.
- R4: The duty cycle of a legal ratio lies within 45–55 % when its period is 50 ns or less (20 MHz and faster), and within 40–60 % otherwise. At a 10 ns system clock this rejects a ratio of 5.
- R5: A `cfg_load_i` pulse with an illegal `cfg_ratio_i` leaves the active ratio unchanged and sets `ratio_err_o`. A later load of a legal ratio adopts that ratio and clears `ratio_err_o`.
- R6: A newly loaded ratio takes effect at the next rising edge of `mclk_o`. The period already under way completes with the old ratio.
- R7: `bit_vld_o` goes high for exactly one system cycle, in the same cycle in which `mclk_o` goes high. `bit_o` then holds the value `mdat_i` had at that rising edge, which is the value the modulator launched after the preceding falling edge.
- R8: `clip_o` goes high once the number of consecutive identical captured bits reaches `clip_thr_i`. `clip_level_o` then gives the repeated value: 1 for the positive rail, 0 for the negative rail. The flag updates one cycle after the strobe.
- R9: `clip_o` clears on the first captured bit that differs from the run, when `clip_thr_i` is greater than 1.
- R10: The run counter saturates at 2^RUN_W−1, so a run longer than that keeps `clip_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load_i | input | 1 | One-cycle pulse that requests `cfg_ratio_i` as the new divide ratio |
| cfg_ratio_i | input | DIV_W | Requested divide ratio (system cycles per modulator clock) |
| clip_thr_i | input | RUN_W | Run length that raises the clip flag |
| mdat_i | input | 1 | Bitstream returned by the modulator |
| mclk_o | output | 1 | Registered modulator clock |
| bit_o | output | 1 | Last captured modulator bit |
| bit_vld_o | output | 1 | One-cycle strobe marking a newly captured bit |
| clip_o | output | 1 | Run of identical bits has reached the threshold |
| clip_level_o | output | 1 | Value of the bit forming the current run |
| ratio_err_o | output | 1 | Last requested ratio was rejected |

## Verification
The assertions assume three things about the inputs. First, `mdat_i` changes only in the low phase of `mclk_o`, after the falling edge and before the next rising edge. Second, `cfg_ratio_i` is valid in the cycle that `cfg_load_i` is high. Third, `clip_thr_i` is held steady while a run is being judged. The bench meets these by having its modulator model change the data line one half system cycle after it sees a falling edge, by driving load pulses for a single cycle with the ratio already set up, and by changing the threshold only between scenarios. Streams with 50 %, 78 % and 22 % ones, constant rails and alternating bits exercise the capture and the run detector.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

  // Captured sample passed from the sampler to the run detector
  typedef struct packed {
    logic vld;
    logic dat;
  } cap_t;

  // Checks a divide ratio against the period, phase and duty windows.
  // The high phase is the rounded-up half, the low phase the rounded-down half.
  function automatic logic ratio_ok(
    input int unsigned n,
    input int unsigned sys_ps,
    input int unsigned per_min,
    input int unsigned per_max,
    input int unsigned ph_min,
    input int unsigned ph_max,
    input int unsigned fast_per,
    input int unsigned duty_wide,
    input int unsigned duty_narrow
  );
    int unsigned per, hi, lo, dmin;
    per  = n * sys_ps;
    hi   = ((n + 1) / 2) * sys_ps;
    lo   = (n / 2) * sys_ps;
    dmin = (per <= fast_per) ? duty_narrow : duty_wide;
    return (per >= per_min) && (per <= per_max) &&
           (hi >= ph_min) && (hi <= ph_max) &&
           (lo >= ph_min) && (lo <= ph_max) &&
           (hi * 100 <= (100 - dmin) * per) &&
           (lo * 100 >= dmin * per);
  endfunction

endpackage

// File: rtl/mdm_ratio_guard.sv
module mdm_ratio_guard #(
  parameter int DIV_W       = 8,
  parameter int SYS_PS      = 10000,
  parameter int PER_MIN_PS  = 45500,
  parameter int PER_MAX_PS  = 200000,
  parameter int PH_MIN_PS   = 20000,
  parameter int PH_MAX_PS   = 120000,
  parameter int FAST_PER_PS = 50000,
  parameter int DUTY_WIDE   = 40,
  parameter int DUTY_NARROW = 45,
  parameter int RESET_RATIO = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DIV_W-1:0] ratio_in,
  output logic [DIV_W-1:0] ratio_q,
  output logic             err_q
);
  import mdm_pkg::*;

  logic legal;

  always_comb begin
    legal = ratio_ok(int'(ratio_in), SYS_PS, PER_MIN_PS, PER_MAX_PS,
                     PH_MIN_PS, PH_MAX_PS, FAST_PER_PS, DUTY_WIDE, DUTY_NARROW);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_q <= DIV_W'(RESET_RATIO);
      err_q   <= 1'b0;
    end else if (load) begin
      if (legal) begin
        ratio_q <= ratio_in;
        err_q   <= 1'b0;
      end else begin
        err_q   <= 1'b1;
      end
    end
  end

  // R5: a rejected request leaves the held ratio alone and flags the error
  p_reject_keeps_r5: assert property (@(posedge clk) disable iff (rst)
    (load && !legal) |=> ($stable(ratio_q) && err_q));

  // R3, R4: the held ratio always meets the period, phase and duty windows
  p_ratio_legal_r3: assert property (@(posedge clk) disable iff (rst)
    ratio_ok(int'(ratio_q), SYS_PS, PER_MIN_PS, PER_MAX_PS, PH_MIN_PS,
             PH_MAX_PS, FAST_PER_PS, DUTY_WIDE, DUTY_NARROW));

endmodule

// File: rtl/mdm_clk_gen.sv
module mdm_clk_gen #(
  parameter int DIV_W       = 8,
  parameter int RESET_RATIO = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] ratio_in,
  output logic             mclk_q,
  output logic             rise_now
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] cur;
  logic [DIV_W-1:0] hi_len;

  assign hi_len   = cur - (cur >> 1);
  assign rise_now = (cnt == cur - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      cur    <= DIV_W'(RESET_RATIO);
      mclk_q <= 1'b0;
    end else if (rise_now) begin
      cnt    <= '0;
      cur    <= ratio_in;
      mclk_q <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
      if (cnt == hi_len - 1'b1) mclk_q <= 1'b0;
    end
  end

  // R2: the phase counter never runs past the active period
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt < cur);

  // R6: the active ratio changes only at a period boundary
  p_switch_on_edge_r6: assert property (@(posedge clk) disable iff (rst)
    !rise_now |=> $stable(cur));

endmodule

// File: rtl/mdm_bit_sampler.sv
module mdm_bit_sampler (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic            mdat,
  output mdm_pkg::cap_t   cap_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q <= '0;
    end else begin
      cap_q.vld <= take;
      if (take) cap_q.dat <= mdat;
    end
  end

  // R7: the captured bit is held between strobes
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(cap_q.dat));

endmodule

// File: rtl/mdm_clip_detect.sv
module mdm_clip_detect #(
  parameter int RUN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  mdm_pkg::cap_t    cap,
  input  logic [RUN_W-1:0] thr,
  output logic             clip_q,
  output logic             level_q
);
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic [RUN_W-1:0] run;
  logic [RUN_W-1:0] run_nx;
  logic             have;
  logic             same;

  assign same = have && (cap.dat == level_q);

  always_comb begin
    if (!same)               run_nx = RUN_W'(1);
    else if (run == RUN_MAX) run_nx = run;
    else                     run_nx = run + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= '0;
      have    <= 1'b0;
      clip_q  <= 1'b0;
      level_q <= 1'b0;
    end else if (cap.vld) begin
      run     <= run_nx;
      have    <= 1'b1;
      level_q <= cap.dat;
      clip_q  <= (run_nx >= thr);
    end
  end

  // R9: a differing bit ends the run and drops the flag
  p_clip_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (cap.vld && have && (cap.dat != level_q) && (thr > RUN_W'(1))) |=> !clip_q);

  // R10: a saturated run stays saturated while the bit repeats
  p_run_sat_r10: assert property (@(posedge clk) disable iff (rst)
    (cap.vld && same && (run == RUN_MAX)) |=> (run == RUN_MAX));

endmodule

// File: rtl/mdm_clk_capture.sv
module mdm_clk_capture #(
  parameter int DIV_W       = 8,
  parameter int RUN_W       = 8,
  parameter int SYS_PS      = 10000,
  parameter int PER_MIN_PS  = 45500,
  parameter int PER_MAX_PS  = 200000,
  parameter int PH_MIN_PS   = 20000,
  parameter int PH_MAX_PS   = 120000,
  parameter int FAST_PER_PS = 50000,
  parameter int DUTY_WIDE   = 40,
  parameter int DUTY_NARROW = 45,
  parameter int RESET_RATIO = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_load_i,
  input  logic [DIV_W-1:0] cfg_ratio_i,
  input  logic [RUN_W-1:0] clip_thr_i,
  input  logic             mdat_i,
  output logic             mclk_o,
  output logic             bit_o,
  output logic             bit_vld_o,
  output logic             clip_o,
  output logic             clip_level_o,
  output logic             ratio_err_o
);
  import mdm_pkg::*;

  logic [DIV_W-1:0] held_ratio;
  logic             rise_now;
  cap_t             cap;

  mdm_ratio_guard #(
    .DIV_W(DIV_W), .SYS_PS(SYS_PS), .PER_MIN_PS(PER_MIN_PS),
    .PER_MAX_PS(PER_MAX_PS), .PH_MIN_PS(PH_MIN_PS), .PH_MAX_PS(PH_MAX_PS),
    .FAST_PER_PS(FAST_PER_PS), .DUTY_WIDE(DUTY_WIDE),
    .DUTY_NARROW(DUTY_NARROW), .RESET_RATIO(RESET_RATIO)
  ) u_guard (
    .clk(clk), .rst(rst), .load(cfg_load_i), .ratio_in(cfg_ratio_i),
    .ratio_q(held_ratio), .err_q(ratio_err_o)
  );

  mdm_clk_gen #(.DIV_W(DIV_W), .RESET_RATIO(RESET_RATIO)) u_gen (
    .clk(clk), .rst(rst), .ratio_in(held_ratio),
    .mclk_q(mclk_o), .rise_now(rise_now)
  );

  mdm_bit_sampler u_smp (
    .clk(clk), .rst(rst), .take(rise_now), .mdat(mdat_i), .cap_q(cap)
  );

  mdm_clip_detect #(.RUN_W(RUN_W)) u_clip (
    .clk(clk), .rst(rst), .cap(cap), .thr(clip_thr_i),
    .clip_q(clip_o), .level_q(clip_level_o)
  );

  assign bit_o     = cap.dat;
  assign bit_vld_o = cap.vld;

  // R1: the cycle after reset shows every output in its idle state
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mclk_o && !bit_vld_o && !clip_o && !ratio_err_o));

  // R7: a strobe only accompanies a rising modulator clock
  p_strobe_on_rise_r7: assert property (@(posedge clk) disable iff (rst)
    bit_vld_o |-> $rose(mclk_o));

  // R7: the strobe lasts one system cycle
  p_strobe_single_r7: assert property (@(posedge clk) disable iff (rst)
    bit_vld_o |=> !bit_vld_o);

endmodule

// File: tb/test_mdm_clk_capture.sv
`timescale 1ns/1ps
module test_mdm_clk_capture;
  localparam int DIV_W = 8;
  localparam int RUN_W = 4;
  localparam int RUN_MAX = (1 << RUN_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_load = 1'b0;
  logic [DIV_W-1:0] cfg_ratio = '0;
  logic [RUN_W-1:0] thr = RUN_W'(15);
  logic mdat = 1'b0;
  logic mclk_o, bit_o, bit_vld_o, clip_o, clip_level_o, ratio_err_o;

  always #5 clk = ~clk;

  mdm_clk_capture #(.DIV_W(DIV_W), .RUN_W(RUN_W)) i_mdm_clk_capture (
    .clk(clk), .rst(rst), .cfg_load_i(cfg_load), .cfg_ratio_i(cfg_ratio),
    .clip_thr_i(thr), .mdat_i(mdat), .mclk_o(mclk_o), .bit_o(bit_o),
    .bit_vld_o(bit_vld_o), .clip_o(clip_o), .clip_level_o(clip_level_o),
    .ratio_err_o(ratio_err_o)
  );

  int checks = 0;
  int errors = 0;
  int mode = 2;     // 0 ones, 1 zeros, 2 alternate, 3 density
  int dens = 50;

  // monitor and modulator model state (written only by the monitor)
  int cyc = 0, nrise = 0, nval = 0, ones = 0;
  int last_rise = -1, per_last = 0, per_prev = 0, hi_meas = 0;
  int cap_bad = 0, clip_bad = 0, acc = 0;
  int exp_run = 0;
  logic exp_lvl = 1'b0, exp_clip = 1'b0, have = 1'b0, pend = 1'b0;
  logic mclk_d = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (mclk_o && !mclk_d) begin
        if (last_rise >= 0) begin
          per_prev = per_last;
          per_last = cyc - last_rise;
        end
        last_rise = cyc;
        nrise++;
      end
      if (!mclk_o && mclk_d) begin
        hi_meas = cyc - last_rise;
        case (mode)
          0: mdat = 1'b1;
          1: mdat = 1'b0;
          2: mdat = ~mdat;
          default: begin
            acc = acc + dens;
            if (acc >= 100) begin acc = acc - 100; mdat = 1'b1; end
            else mdat = 1'b0;
          end
        endcase
      end
      if (pend) begin
        pend = 1'b0;
        if (clip_o !== exp_clip || (exp_clip && clip_level_o !== exp_lvl)) clip_bad++;
      end
      if (bit_vld_o) begin
        nval++;
        if (bit_o !== mdat) cap_bad++;
        if (bit_o) ones++;
        if (have && bit_o == exp_lvl) begin
          if (exp_run < RUN_MAX) exp_run++;
        end else exp_run = 1;
        have = 1'b1;
        exp_lvl = bit_o;
        exp_clip = (exp_run >= int'(thr));
        pend = 1'b1;
      end
    end
    mclk_d = mclk_o;
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_rises(input int n);
    int s = nrise;
    while (nrise < s + n) step();
  endtask

  task automatic wait_vals(input int n);
    int s = nval;
    while (nval < s + n) step();
    step();
    step();
  endtask

  task automatic load(input int n);
    cfg_ratio = DIV_W'(n);
    cfg_load = 1'b1;
    step();
    cfg_load = 1'b0;
    step();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) step();
    chk("R1 mclk in reset", int'(mclk_o), 0);
    chk("R1 strobe in reset", int'(bit_vld_o), 0);
    chk("R1 clip in reset", int'(clip_o), 0);
    chk("R1 error in reset", int'(ratio_err_o), 0);
    rst = 1'b0;
    step();
    chk("R1 mclk after reset", int'(mclk_o), 0);
    wait_rises(3);
    chk("R1 reset ratio period", per_last, 6);
    step();
    step();
    step();
    chk("R2 high phase ratio 6", hi_meas, 3);
  endtask

  task automatic t_ratio_legal();
    load(7);
    chk("R5 error after legal 7", int'(ratio_err_o), 0);
    wait_rises(3);
    step(); step(); step(); step(); step();
    chk("R2 period ratio 7", per_last, 7);
    chk("R2 high phase ratio 7", hi_meas, 4);
    load(20);
    wait_rises(3);
    repeat (11) step();
    chk("R3 period ratio 20", per_last, 20);
    chk("R2 high phase ratio 20", hi_meas, 10);
  endtask

  task automatic t_ratio_reject();
    load(4);
    chk("R3 error for 4", int'(ratio_err_o), 1);
    wait_rises(2);
    chk("R5 kept ratio after 4", per_last, 20);
    load(5);
    chk("R4 error for 5", int'(ratio_err_o), 1);
    load(21);
    chk("R3 error for 21", int'(ratio_err_o), 1);
    load(1);
    wait_rises(2);
    chk("R5 kept ratio after rejects", per_last, 20);
    load(13);
    chk("R5 error cleared by 13", int'(ratio_err_o), 0);
    wait_rises(3);
    chk("R4 period ratio 13", per_last, 13);
  endtask

  task automatic t_switch();
    load(6);
    wait_rises(3);
    step();
    step();
    load(9);
    wait_rises(2);
    chk("R6 period under way keeps old ratio", per_prev, 6);
    chk("R6 next period uses new ratio", per_last, 9);
  endtask

  task automatic t_density(input int k);
    int s_bad = cap_bad;
    int s_ones;
    mode = 3;
    dens = k;
    wait_vals(4);
    s_ones = ones;
    wait_vals(100);
    chk($sformatf("R7 capture mismatches at %0d pct", k), cap_bad - s_bad, 0);
    chk($sformatf("R7 ones count near %0d", k),
        ((ones - s_ones >= k - 2) && (ones - s_ones <= k + 2)) ? 1 : 0, 1);
  endtask

  task automatic t_clip();
    int s_bad = clip_bad;
    thr = RUN_W'(6);
    mode = 2;
    wait_vals(20);
    chk("R9 no clip on alternating bits", int'(clip_o), 0);
    mode = 0;
    wait_vals(20);
    chk("R8 clip on positive rail", int'(clip_o), 1);
    chk("R8 clip level positive", int'(clip_level_o), 1);
    mode = 1;
    wait_vals(2);
    chk("R9 clip cleared by differing bit", int'(clip_o), 0);
    wait_vals(20);
    chk("R8 clip on negative rail", int'(clip_o), 1);
    chk("R8 clip level negative", int'(clip_level_o), 0);
    chk("R8 R9 clip timing per bit", clip_bad - s_bad, 0);
  endtask

  task automatic t_saturate();
    int s_bad = clip_bad;
    mode = 2;
    wait_vals(4);
    thr = RUN_W'(RUN_MAX);
    mode = 0;
    wait_vals(40);
    chk("R10 clip held past counter limit", int'(clip_o), 1);
    chk("R10 clip timing per bit", clip_bad - s_bad, 0);
  endtask

  logic wd = 1'b0;

  initial begin
    fork
      begin
        t_reset();
        t_ratio_legal();
        t_ratio_reject();
        t_switch();
        t_density(50);
        t_density(78);
        t_density(22);
        t_clip();
        t_saturate();
      end
      begin
        repeat (150000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule